// File: doc/BRIEF.md
# Dual Capture/Compare Event and Interrupt Unit

This block serves one channel of a 16-bit timer. It has two capture/compare slots, numbered 0 and 1. Each slot runs on its own in either compare or capture mode, and a mode pin selects which. The timer counter comes in as an input.

In capture mode, a rising edge on the slot's asynchronous trigger pin stores the counter value that is present at that moment. In compare mode, a software-written buffer value is moved into the slot's active register each time the counter wraps to zero. The slot then raises a compare event whenever the counter equals that active value.

Every event type sets a sticky flag: compare, capture, and capture overwrite, for each slot. Each flag has its own enable bit. A single registered interrupt request is raised while any flag is set whose enable bit is also set. A one-cycle write strobe gives software four things: it clears flags by writing 1, it loads the enable register, and it loads the two compare buffers. The flags, the enables and both active register values are always visible on output pins. No data stream crosses the block's edge, so every pin is a plain control or status signal with no valid/ready handshake.

Top module: `ccu_irq_unit`

## Requirements
- R1: In capture mode, a trigger that rises before clock edge E0 passes a two-flop synchroniser and an edge detector. At edge E2 the slot register takes the `counter_i` value present before that edge, and capture flag bit 2+s is set (s is the slot number). After the E1 edge the register is still unchanged.
- R2: A capture into slot s while capture flag 2+s is already 1 sets overwrite flag bit 4+s. A capture while that flag is 0 leaves the overwrite flag clear.
- R3: In compare mode, compare flag bit s sets on any clock edge at which `counter_i` equals the active register of slot s. It does not set for counter values below the active value.
- R4: A write to address 2 loads the buffer of slot 0, and a write to address 3 loads the buffer of slot 1. The buffer reaches the active register only on an edge where `counter_i` is zero and the slot is in compare mode. In capture mode a zero counter never changes the register.
- R5: In compare mode a trigger edge changes neither the slot register nor its capture flag. In capture mode the compare flag never sets, even when the counter equals the register.
- R6: A write to address 0 clears each flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. If a hardware set and a clear hit the same bit on the same edge, the flag stays 1.
- R7: A write to address 1 loads the six-bit enable register from `wr_data_i[5:0]`. The enable register is shown on `irq_en_o`. Enable bits use the same layout as the flag bits.
- R8: `irq_o` is registered. One cycle after the enable or flag state changes, it equals the OR over all bits of (flags AND enables).
- R9: After reset, all flags and enables are 0, `irq_o` is 0, and both active registers and both buffers hold 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| counter_i | input | 16 | Timer counter value |
| cap_mode_i | input | 2 | Per slot: 1 = capture mode, 0 = compare mode |
| cap_trig_i | input | 2 | Per slot: asynchronous capture trigger |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wr_addr_i | input | 2 | 0 = flag clear, 1 = enables, 2/3 = buffer of slot 0/1 |
| wr_data_i | input | 16 | Write data |
| cc_val_o | output | 32 | Active registers, slot s in bits [16s+15:16s] |
| flags_o | output | 6 | Sticky flags: [1:0] compare, [3:2] capture, [5:4] overwrite |
| irq_en_o | output | 6 | Interrupt enables |
| irq_o | output | 1 | Interrupt request |

## Verification
The compare function is swept with every target from 1 to 10 on both slots. The counter steps upward to the target, so an early match shows up as a flag set before the target is reached. The capture function uses four counter values: all zeros, all ones, a high-bit pattern and a mixed pattern. Each value is captured twice, so the first capture shows the overwrite flag held low and the second shows it raised. The all-zeros value also shows that a zero counter does not reload a register in capture mode. The interrupt output is checked against all 64 enable patterns, once with every flag set and once with alternate flags set. This catches any flag-to-enable pairing that is swapped or missing.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int CNT_W_DEF  = 16;
  localparam int NUM_CC_DEF = 2;
  localparam int SYNC_STAGES = 2;
  // write address map
  localparam int ADDR_FLAG_CLR = 0;
  localparam int ADDR_IRQ_EN   = 1;
  localparam int ADDR_BUF_BASE = 2;
  // flag groups, each NUM_CC bits wide: compare, capture, overwrite
  localparam int GRP_CMP = 0;
  localparam int GRP_CAP = 1;
  localparam int GRP_OVW = 2;
  localparam int NUM_GRP = 3;
endpackage

// File: rtl/ccu_trig_sync.sv
module ccu_trig_sync #(
  parameter int STAGES = ccu_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], raw_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/ccu_cc_slot.sv
module ccu_cc_slot #(
  parameter int CNT_W = ccu_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] counter_i,
  input  logic             cap_mode_i,
  input  logic             trig_rise_i,
  input  logic             buf_we_i,
  input  logic [CNT_W-1:0] buf_wdata_i,
  output logic [CNT_W-1:0] cc_o,
  output logic             cmp_hit_o,
  output logic             cap_hit_o
);
  logic [CNT_W-1:0] buf_q;
  logic [CNT_W-1:0] cc_q;
  logic             wrap;

  assign wrap      = (counter_i == '0);
  assign cap_hit_o = cap_mode_i & trig_rise_i;
  assign cmp_hit_o = ~cap_mode_i & (counter_i == cc_q);
  assign cc_o      = cc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) buf_q <= '1;
    else if (buf_we_i) buf_q <= buf_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cc_q <= '1;
    else if (cap_hit_o)           cc_q <= counter_i;
    else if (!cap_mode_i && wrap) cc_q <= buf_q;
  end
endmodule

// File: rtl/ccu_flag_bank.sv
module ccu_flag_bank #(
  parameter int NUM_CC = ccu_pkg::NUM_CC_DEF,
  localparam int FW    = ccu_pkg::NUM_GRP * NUM_CC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CC-1:0] cmp_hit_i,
  input  logic [NUM_CC-1:0] cap_hit_i,
  input  logic [FW-1:0]     clr_i,
  input  logic              en_we_i,
  input  logic [FW-1:0]     en_wdata_i,
  output logic [FW-1:0]     flags_o,
  output logic [FW-1:0]     en_o,
  output logic              irq_o
);
  logic [FW-1:0]     flags_q, en_q, set_vec;
  logic [NUM_CC-1:0] cap_pend;
  logic              irq_q;

  assign cap_pend = flags_q[ccu_pkg::GRP_CAP*NUM_CC +: NUM_CC];
  assign set_vec  = {cap_hit_i & cap_pend, cap_hit_i, cmp_hit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      en_q    <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_i) | set_vec;
      if (en_we_i) en_q <= en_wdata_i;
      irq_q   <= |(flags_q & en_q);
    end
  end

  assign flags_o = flags_q;
  assign en_o    = en_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/ccu_irq_unit.sv
module ccu_irq_unit #(
  parameter int CNT_W  = ccu_pkg::CNT_W_DEF,
  parameter int NUM_CC = ccu_pkg::NUM_CC_DEF,
  localparam int FW    = ccu_pkg::NUM_GRP * NUM_CC,
  localparam int AW    = $clog2(ccu_pkg::ADDR_BUF_BASE + NUM_CC)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CNT_W-1:0]        counter_i,
  input  logic [NUM_CC-1:0]       cap_mode_i,
  input  logic [NUM_CC-1:0]       cap_trig_i,
  input  logic                    wr_en_i,
  input  logic [AW-1:0]           wr_addr_i,
  input  logic [CNT_W-1:0]        wr_data_i,
  output logic [NUM_CC*CNT_W-1:0] cc_val_o,
  output logic [FW-1:0]           flags_o,
  output logic [FW-1:0]           irq_en_o,
  output logic                    irq_o
);
  logic [NUM_CC-1:0] trig_rise, cmp_hit, cap_hit;
  logic [FW-1:0]     clr_vec;
  logic              en_we;

  assign clr_vec = (wr_en_i && wr_addr_i == AW'(ccu_pkg::ADDR_FLAG_CLR))
                   ? wr_data_i[FW-1:0] : '0;
  assign en_we   = wr_en_i && (wr_addr_i == AW'(ccu_pkg::ADDR_IRQ_EN));

  for (genvar s = 0; s < NUM_CC; s++) begin : g_slot
    logic buf_we;
    assign buf_we = wr_en_i && (wr_addr_i == AW'(ccu_pkg::ADDR_BUF_BASE + s));

    ccu_trig_sync #(.STAGES(ccu_pkg::SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw_i  (cap_trig_i[s]),
      .rise_o (trig_rise[s])
    );

    ccu_cc_slot #(.CNT_W(CNT_W)) u_slot (
      .clk         (clk),
      .rst_n       (rst_n),
      .counter_i   (counter_i),
      .cap_mode_i  (cap_mode_i[s]),
      .trig_rise_i (trig_rise[s]),
      .buf_we_i    (buf_we),
      .buf_wdata_i (wr_data_i),
      .cc_o        (cc_val_o[s*CNT_W +: CNT_W]),
      .cmp_hit_o   (cmp_hit[s]),
      .cap_hit_o   (cap_hit[s])
    );
  end

  ccu_flag_bank #(.NUM_CC(NUM_CC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmp_hit_i  (cmp_hit),
    .cap_hit_i  (cap_hit),
    .clr_i      (clr_vec),
    .en_we_i    (en_we),
    .en_wdata_i (wr_data_i[FW-1:0]),
    .flags_o    (flags_o),
    .en_o       (irq_en_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/ccu_irq_chk.sv
module ccu_irq_chk #(
  parameter int CNT_W  = 16,
  parameter int NUM_CC = 2,
  localparam int FW    = 3 * NUM_CC,
  localparam int AW    = $clog2(2 + NUM_CC)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CNT_W-1:0]        counter_i,
  input logic [NUM_CC-1:0]       cap_mode_i,
  input logic                    wr_en_i,
  input logic [AW-1:0]           wr_addr_i,
  input logic [FW-1:0]           wr_data_i,
  input logic [NUM_CC*CNT_W-1:0] cc_val_o,
  input logic [FW-1:0]           flags_o,
  input logic [FW-1:0]           irq_en_o,
  input logic                    irq_o
);
  logic [FW-1:0] sw_clr;
  assign sw_clr = (wr_en_i && wr_addr_i == '0) ? wr_data_i : '0;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & $past(flags_o & ~sw_clr)) == $past(flags_o & ~sw_clr)));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(|(flags_o & irq_en_o)));

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_o & irq_en_o)) |=> irq_o);

  for (genvar s = 0; s < NUM_CC; s++) begin : g_chk
    // R2
    ovw_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[2*NUM_CC+s]) |-> $past(flags_o[NUM_CC+s]));

    // R5
    cmp_only_in_cmp_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[s]) |-> $past(!cap_mode_i[s]));

    // R5
    cap_only_in_cap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags_o[NUM_CC+s]) |-> $past(cap_mode_i[s]));

    // R4
    cc_change_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cc_val_o[s*CNT_W +: CNT_W]) |-> $past(cap_mode_i[s] || counter_i == '0));
  end
endmodule

bind ccu_irq_unit ccu_irq_chk #(.CNT_W(CNT_W), .NUM_CC(NUM_CC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .counter_i  (counter_i),
  .cap_mode_i (cap_mode_i),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i[3*NUM_CC-1:0]),
  .cc_val_o   (cc_val_o),
  .flags_o    (flags_o),
  .irq_en_o   (irq_en_o),
  .irq_o      (irq_o)
);

// File: tb/tb_ccu_irq_unit.sv
module tb_ccu_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] counter_i = '0;
  logic [1:0]  cap_mode_i = '0;
  logic [1:0]  cap_trig_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [31:0] cc_val_o;
  logic [5:0]  flags_o, irq_en_o;
  logic        irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  ccu_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .counter_i(counter_i), .cap_mode_i(cap_mode_i),
    .cap_trig_i(cap_trig_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .cc_val_o(cc_val_o), .flags_o(flags_o),
    .irq_en_o(irq_en_o), .irq_o(irq_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc >= WATCHDOG) begin
      n_fail++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    tick();
    wr_en_i = 1'b0;
  endtask

  task automatic pulse(input int s);
    cap_trig_i[s] = 1'b1;
    repeat (3) tick();
    cap_trig_i[s] = 1'b0;
    repeat (3) tick();
  endtask

  function automatic logic [15:0] cc(input int s);
    return cc_val_o[s*16 +: 16];
  endfunction

  function automatic logic [15:0] cap_val(input int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h1234;
      2: return 16'hFFFF;
      default: return 16'h8001;
    endcase
  endfunction

  initial begin
    logic [15:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    chk("R9 flags", {26'd0, flags_o}, 32'd0);
    chk("R9 enables", {26'd0, irq_en_o}, 32'd0);
    chk("R9 irq", {31'd0, irq_o}, 32'd0);
    chk("R9 cc0", {16'd0, cc(0)}, 32'h0000FFFF);
    chk("R9 cc1", {16'd0, cc(1)}, 32'h0000FFFF);

    // R3 / R4 compare sweep over targets 1..10 on both slots
    cap_mode_i = 2'b00;
    for (int s = 0; s < 2; s++) begin
      for (int t = 1; t <= 10; t++) begin
        logic early;
        wr(2'(2 + s), 16'(t));
        counter_i = 16'd0;
        tick();
        chk("R4 buffer load at wrap", {16'd0, cc(s)}, t);
        wr(2'd0, 16'h003F);
        early = 1'b0;
        for (int c = 1; c < t; c++) begin
          counter_i = 16'(c);
          tick();
          early = early | flags_o[s];
        end
        chk("R3 no early compare", {31'd0, early}, 32'd0);
        counter_i = 16'(t);
        tick();
        chk("R3 compare flag at match", {31'd0, flags_o[s]}, 32'd1);
      end
    end

    // R4 buffer does not reach active register while counter nonzero
    counter_i = 16'd5;
    wr(2'd2, 16'd50);
    tick();
    chk("R4 hold while nonzero", {16'd0, cc(0)}, 32'd10);
    counter_i = 16'd0;
    tick();
    chk("R4 load on wrap", {16'd0, cc(0)}, 32'd50);
    chk("R4 slot1 keeps own buffer", {16'd0, cc(1)}, 32'd10);

    // R6 set wins over clear, zero bits no effect
    wr(2'd0, 16'h003F);
    counter_i = 16'd50;
    tick();
    chk("R6 flag set", {31'd0, flags_o[0]}, 32'd1);
    wr(2'd0, 16'h0001);
    chk("R6 set beats clear", {31'd0, flags_o[0]}, 32'd1);
    counter_i = 16'd51;
    wr(2'd0, 16'h0000);
    chk("R6 write zero no effect", {31'd0, flags_o[0]}, 32'd1);
    wr(2'd0, 16'h0002);
    chk("R6 other bit clear no effect", {31'd0, flags_o[0]}, 32'd1);
    wr(2'd0, 16'h0001);
    chk("R6 write one clears", {31'd0, flags_o[0]}, 32'd0);

    // R1 synchroniser latency
    cap_mode_i = 2'b11;
    counter_i = 16'hABCD;
    keep = cc(0);
    cap_trig_i[0] = 1'b1;
    tick(); tick();
    chk("R1 not yet captured after two edges", {16'd0, cc(0)}, {16'd0, keep});
    tick();
    chk("R1 captured on third edge", {16'd0, cc(0)}, 32'h0000ABCD);
    cap_trig_i[0] = 1'b0;
    repeat (3) tick();

    // R1 / R2 / R5 capture sweep
    for (int s = 0; s < 2; s++) begin
      for (int i = 0; i < 4; i++) begin
        logic [15:0] v;
        v = cap_val(i);
        counter_i = v;
        wr(2'd0, 16'h003F);
        pulse(s);
        chk("R1 captured value", {16'd0, cc(s)}, {16'd0, v});
        chk("R1 capture flag", {31'd0, flags_o[2+s]}, 32'd1);
        chk("R2 no overwrite on first", {31'd0, flags_o[4+s]}, 32'd0);
        counter_i = ~v;
        pulse(s);
        chk("R1 recaptured value", {16'd0, cc(s)}, {16'd0, ~v});
        chk("R2 overwrite on second", {31'd0, flags_o[4+s]}, 32'd1);
        chk("R5 no compare in capture mode", {31'd0, flags_o[s]}, 32'd0);
      end
    end

    // R5 trigger ignored in compare mode
    cap_mode_i = 2'b00;
    counter_i = 16'h0077;
    tick();
    wr(2'd0, 16'h003F);
    keep = cc(0);
    pulse(0);
    chk("R5 trigger ignored value", {16'd0, cc(0)}, {16'd0, keep});
    chk("R5 trigger ignored flag", {31'd0, flags_o[2]}, 32'd0);

    // R7 / R8 set all flags then sweep enables
    cap_mode_i = 2'b11;
    counter_i = 16'h0010;
    pulse(0); pulse(0); pulse(1); pulse(1);
    cap_mode_i = 2'b00;
    tick();
    cap_mode_i = 2'b11;
    counter_i = 16'h0020;
    tick();
    chk("R7 all flags set", {26'd0, flags_o}, 32'h3F);
    for (int e = 0; e < 64; e++) begin
      wr(2'd1, 16'(e));
      tick();
      chk("R7 enable readback", {26'd0, irq_en_o}, e);
      chk("R8 irq all flags", {31'd0, irq_o}, {31'd0, e != 0});
    end
    wr(2'd0, 16'h0015);
    chk("R6 alternate clear", {26'd0, flags_o}, 32'h2A);
    for (int e = 0; e < 64; e++) begin
      wr(2'd1, 16'(e));
      tick();
      chk("R8 irq partial flags", {31'd0, irq_o}, {31'd0, (e & 32'h2A) != 0});
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule